// File: doc/BRIEF.md
# Microcoded March Test Sequencer

This block steps a March memory test held in a small microcode store. Each 7-bit word stands for one memory operation. The sequencer fetches a word, applies it to the current address and then picks the next word. It tracks the element position flagged in each word. Within a multi-operation element it runs every operation at one address and then returns to the element's first word at the next address. When an element has covered the whole address range, it moves on to the next element. The address walks up or down as each element's words direct.

The block drives address, write data and one-cycle read or write strobes to a memory under test. That memory is assumed to have a synchronous read with one cycle of latency. For each read, the sequencer presents the expected data with a compare strobe in the cycle the read data appears, so an external comparator can judge it. The algorithm lives entirely in the `PROGRAM` parameter, so a different store content gives a different test. A start pulse launches the test and `done` reports that the terminating word was reached.

All pins are plain control and data pins with no valid/ready handshake. The memory port is a fixed-timing command port, and the comparator must accept a compare in every cycle in which `cmp_valid` is high. No back-pressure is possible.

Top module: `march_seq`

## Requirements
- R1: A microword holds, from bit 6 down to bit 0: valid, the three position flags (bit 5, bit 4, bit 3), direction (1 = ascending), access kind (1 = read, 0 = write) and pattern (1 = all ones, 0 = all zeros). The default store holds, in this order: W0 ascending; ascending (W0,R0,R0); ascending (W1,R1,R1); descending (W1,R1,R1); descending (W0,R0,R0); R0 descending; then a word with valid = 0.
- R2: The position flags, read as bits {5,4,3}, mean 111 = single-operation element, 011 = first, 101 = middle and 110 = last operation of a multi-operation element. All operations of an element are applied to one address before the address changes.
- R3: An element whose first word has direction 1 starts at address 0 and steps up to 15. With direction 0 it starts at 15 and steps down to 0. After the terminal address, the next element starts.
- R4: A write operation pulses `mem_we` for one cycle with `mem_wdata` all ones or all zeros per the pattern bit. A read pulses `mem_re` for one cycle. `mem_addr` carries the operation's address during the pulse.
- R5: In the cycle after each `mem_re` pulse, `cmp_valid` is high for one cycle and `exp_data` holds the read's pattern (all ones or all zeros).
- R6: Each operation takes two cycles. If start is sampled at clock edge 1, the first strobe appears after edge 3 and operation k's strobe appears after edge 3+2k. `mem_we` and `mem_re` are never high together.
- R7: Fetching a word with valid = 0 ends the test. `done` rises after the edge that follows that fetch (edge 2+2N for N operations) and stays high with no strobes until the next start.
- R8: Start is ignored while a test runs. Start while idle or done restarts the program from word 0.
- R9: Active-low `rst_n` clears the strobes, `cmp_valid`, the data outputs, the address and `done`, and the block then waits for start.
- R10: Replacing `PROGRAM` produces exactly the operation sequence that the replacement words describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches the test when idle or done |
| done | output | 1 | High once the terminating word was fetched |
| mem_addr | output | ADDR_W | Address of the current operation |
| mem_wdata | output | DATA_W | Pattern of the current operation (write data) |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe |
| exp_data | output | DATA_W | Expected read data for the comparator |
| cmp_valid | output | 1 | Compare strobe, one cycle after `mem_re` |

## Verification
The assertions check, on every cycle, the properties of the strobes taken one at a time. The two strobes are exclusive, and two operations never follow back to back. A compare strobe follows each read. `done` holds with no memory activity. Only the bench's scenarios can show that the element looping, the address orders and the per-address operation order match the program. They also cover the exact issue cycle of each operation, the ignored start during a run, the reset in the middle of a run and the second program in another instance. The bench's reference expands each program into its full list of operations and compares every output on every clock.

// File: rtl/march_pkg.sv
package march_pkg;
  typedef struct packed {
    logic       vld;
    logic [2:0] pos;
    logic       up;
    logic       rd;
    logic       ones;
  } mword_t;

  localparam int MW_W      = $bits(mword_t);
  localparam int DEF_DEPTH = 16;

  localparam logic [2:0] POS_SINGLE = 3'b111;
  localparam logic [2:0] POS_FIRST  = 3'b011;
  localparam logic [2:0] POS_MID    = 3'b101;
  localparam logic [2:0] POS_LAST   = 3'b110;

  function automatic logic opens_elem(input logic [2:0] pos);
    return (pos == POS_SINGLE) || (pos == POS_FIRST);
  endfunction

  function automatic logic closes_elem(input logic [2:0] pos);
    return (pos == POS_SINGLE) || (pos == POS_LAST);
  endfunction

  // Default algorithm: 14 operations followed by an invalid word (R1)
  function automatic logic [DEF_DEPTH*MW_W-1:0] default_program();
    logic [DEF_DEPTH*MW_W-1:0] p;
    p = '0;
    p[ 0*MW_W +: MW_W] = 7'b1111100;
    p[ 1*MW_W +: MW_W] = 7'b1011100;
    p[ 2*MW_W +: MW_W] = 7'b1101110;
    p[ 3*MW_W +: MW_W] = 7'b1110110;
    p[ 4*MW_W +: MW_W] = 7'b1011101;
    p[ 5*MW_W +: MW_W] = 7'b1101111;
    p[ 6*MW_W +: MW_W] = 7'b1110111;
    p[ 7*MW_W +: MW_W] = 7'b1011001;
    p[ 8*MW_W +: MW_W] = 7'b1101011;
    p[ 9*MW_W +: MW_W] = 7'b1110011;
    p[10*MW_W +: MW_W] = 7'b1011000;
    p[11*MW_W +: MW_W] = 7'b1101010;
    p[12*MW_W +: MW_W] = 7'b1110010;
    p[13*MW_W +: MW_W] = 7'b1111010;
    return p;
  endfunction
endpackage

// File: rtl/march_store.sv
module march_store
  import march_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH),
  parameter logic [DEPTH*MW_W-1:0] PROGRAM = '0
) (
  input  logic [PTR_W-1:0] ptr,
  output mword_t           word
);
  logic [MW_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = PROGRAM[g*MW_W +: MW_W];
  end

  assign word = mword_t'(rom[ptr]);
endmodule

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              up,
  output logic [ADDR_W-1:0] addr,
  output logic              at_end
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  assign at_end = up ? (addr == TOP) : (addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= up ? '0 : TOP;
    end else if (step) begin
      addr <= up ? addr + 1'b1 : addr - 1'b1;
    end
  end
endmodule

// File: rtl/march_ctrl.sv
module march_ctrl
  import march_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  mword_t           word,
  input  logic             at_end,
  output logic [PTR_W-1:0] ptr,
  output mword_t           ir,
  output logic             issue,
  output logic             addr_load,
  output logic             addr_step,
  output logic             addr_up,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC, S_FIN} state_t;

  state_t           state;
  logic [PTR_W-1:0] elem_ptr;
  logic             new_elem;

  assign issue     = (state == S_EXEC);
  assign addr_load = (state == S_FETCH) && word.vld && new_elem;
  assign addr_step = issue && closes_elem(ir.pos) && !at_end;
  assign addr_up   = (state == S_FETCH) ? word.up : ir.up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ptr      <= '0;
      ir       <= '0;
      elem_ptr <= '0;
      new_elem <= 1'b0;
      done     <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_FIN: begin
          if (start) begin
            ptr      <= '0;
            new_elem <= 1'b1;
            done     <= 1'b0;
            state    <= S_FETCH;
          end
        end
        S_FETCH: begin
          ir <= word;
          if (!word.vld) begin
            done  <= 1'b1;
            state <= S_FIN;
          end else begin
            if (opens_elem(word.pos)) elem_ptr <= ptr;
            new_elem <= 1'b0;
            state    <= S_EXEC;
          end
        end
        S_EXEC: begin
          state <= S_FETCH;
          if (closes_elem(ir.pos) && !at_end) begin
            ptr <= elem_ptr;
          end else begin
            ptr <= ptr + 1'b1;
            if (closes_elem(ir.pos)) new_elem <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/march_port.sv
module march_port #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              rd,
  input  logic              ones,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] exp_data,
  output logic              cmp_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      exp_data  <= '0;
      cmp_valid <= 1'b0;
    end else begin
      mem_we    <= issue && !rd;
      mem_re    <= issue && rd;
      cmp_valid <= mem_re;
      if (issue) begin
        mem_addr  <= addr;
        mem_wdata <= {DATA_W{ones}};
      end
      if (mem_re) exp_data <= mem_wdata;
    end
  end
endmodule

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int PROG_DEPTH = DEF_DEPTH,
  parameter logic [PROG_DEPTH*MW_W-1:0] PROGRAM = default_program()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] exp_data,
  output logic              cmp_valid
);
  localparam int PTR_W = (PROG_DEPTH > 1) ? $clog2(PROG_DEPTH) : 1;

  logic [PTR_W-1:0]  ptr;
  mword_t            word;
  mword_t            ir;
  logic              issue;
  logic              addr_load;
  logic              addr_step;
  logic              addr_up;
  logic              at_end;
  logic [ADDR_W-1:0] addr;

  march_store #(.DEPTH(PROG_DEPTH), .PTR_W(PTR_W), .PROGRAM(PROGRAM)) u_store (
    .ptr  (ptr),
    .word (word)
  );

  march_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .word      (word),
    .at_end    (at_end),
    .ptr       (ptr),
    .ir        (ir),
    .issue     (issue),
    .addr_load (addr_load),
    .addr_step (addr_step),
    .addr_up   (addr_up),
    .done      (done)
  );

  march_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (addr_load),
    .step   (addr_step),
    .up     (addr_up),
    .addr   (addr),
    .at_end (at_end)
  );

  march_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .rd        (ir.rd),
    .ones      (ir.ones),
    .addr      (addr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .exp_data  (exp_data),
    .cmp_valid (cmp_valid)
  );
endmodule

// File: rtl/march_seq_checker.sv
module march_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic done,
  input logic mem_we,
  input logic mem_re,
  input logic cmp_valid
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R6

  AST_OP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |=> !(mem_we || mem_re)); // R6

  AST_CMP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> cmp_valid); // R5

  AST_CMP_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> $past(mem_re)); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(mem_we || mem_re)); // R7

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R7
endmodule

bind march_seq march_seq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .cmp_valid (cmp_valid)
);

// File: tb/march_seq_tb.sv
module march_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  // Bench's own copy of the default algorithm (R1), word 0 in the low bits
  localparam logic [111:0] PROG_A = {14'b0,
    7'b1111010, 7'b1110010, 7'b1101010, 7'b1011000, 7'b1110011, 7'b1101011, 7'b1011001,
    7'b1110111, 7'b1101111, 7'b1011101, 7'b1110110, 7'b1101110, 7'b1011100, 7'b1111100};
  // Second algorithm: W1 up; down(R1,W0); R0 up (R10)
  localparam logic [111:0] PROG_B = {84'b0,
    7'b1111110, 7'b1110000, 7'b1011011, 7'b1111101};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;

  logic       done_a, we_a, re_a, cv_a;
  logic [3:0] addr_a;
  logic [7:0] wd_a, ed_a;
  logic       done_b, we_b, re_b, cv_b;
  logic [3:0] addr_b;
  logic [7:0] wd_b, ed_b;

  int n_checks = 0;
  int n_errors = 0;
  int n_cycles = 0;

  int         n_ops [2];
  logic [3:0] e_addr [2][512];
  logic       e_rd   [2][512];
  logic       e_one  [2][512];
  int         cnt [2];
  logic       st_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  march_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done_a),
    .mem_addr(addr_a), .mem_wdata(wd_a), .mem_we(we_a), .mem_re(re_a),
    .exp_data(ed_a), .cmp_valid(cv_a)
  );

  march_seq #(.PROGRAM(PROG_B)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done_b),
    .mem_addr(addr_b), .mem_wdata(wd_b), .mem_we(we_b), .mem_re(re_b),
    .exp_data(ed_b), .cmp_valid(cv_b)
  );

  task automatic check_val(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expand a program into its flat list of operations (R2, R3)
  task automatic expand(int d, logic [111:0] prog);
    int i;
    int n;
    i = 0;
    n = 0;
    while (i < 16 && prog[i*7+6]) begin
      int s;
      int e;
      logic up;
      s = i;
      e = i;
      while (e < 15 && !(prog[e*7+3 +: 3] == 3'b111 || prog[e*7+3 +: 3] == 3'b110)) e++;
      up = prog[s*7+2];
      for (int k = 0; k < 16; k++) begin
        for (int j = s; j <= e; j++) begin
          e_addr[d][n] = up ? 4'(k) : 4'(15 - k);
          e_rd[d][n]   = prog[j*7+1];
          e_one[d][n]  = prog[j*7];
          n++;
        end
      end
      i = e + 1;
    end
    n_ops[d] = n;
  endtask

  task automatic compare(int d, logic we, logic re, logic [3:0] a, logic [7:0] wd,
                         logic cv, logic [7:0] ed, logic dn);
    string p;
    int c;
    int n;
    p = (d == 1) ? "R10" : "R1";
    c = cnt[d];
    n = n_ops[d];
    if (c < 0) begin
      check_val("R9", "idle we", int'(we), 0);
      check_val("R9", "idle re", int'(re), 0);
      check_val("R9", "idle cmp_valid", int'(cv), 0);
      check_val("R9", "idle done", int'(dn), 0);
    end else begin
      logic strobe;
      logic cmpx;
      int k;
      int k2;
      strobe = (c >= 3) && (c % 2 == 1) && ((c - 3) / 2 < n);
      k = strobe ? (c - 3) / 2 : 0;
      check_val({p, " R2 R6 R8"}, "mem_we", int'(we), int'(strobe && !e_rd[d][k]));
      check_val({p, " R2 R6 R8"}, "mem_re", int'(re), int'(strobe && e_rd[d][k]));
      if (strobe) begin
        check_val({p, " R3"}, "mem_addr", int'(a), int'(e_addr[d][k]));
        check_val({p, " R4"}, "mem_wdata", int'(wd), e_one[d][k] ? 8'hFF : 8'h00);
      end
      cmpx = (c >= 4) && (c % 2 == 0) && ((c - 4) / 2 < n) && e_rd[d][(c - 4) / 2];
      check_val({p, " R5"}, "cmp_valid", int'(cv), int'(cmpx));
      if (cmpx) begin
        k2 = (c - 4) / 2;
        check_val({p, " R5"}, "exp_data", int'(ed), e_one[d][k2] ? 8'hFF : 8'h00);
      end
      check_val({p, " R7"}, "done", int'(dn), int'(c >= 2 + 2*n));
    end
  endtask

  always @(posedge clk) st_q <= start;

  // Reference model advance and per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    n_cycles++;
    for (int d = 0; d < 2; d++) begin
      if (!rst_n) cnt[d] = -1;
      else if (st_q && (cnt[d] < 0 || cnt[d] >= 2 + 2*n_ops[d])) cnt[d] = 1;
      else if (cnt[d] >= 1) cnt[d]++;
    end
    compare(0, we_a, re_a, addr_a, wd_a, cv_a, ed_a, done_a);
    compare(1, we_b, re_b, addr_b, wd_b, cv_b, ed_b, done_b);
    if (n_cycles > WATCHDOG) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", n_cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    tick(1);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!(done_a && done_b)) tick(1);
    tick(4);
  endtask

  initial begin
    cnt[0] = -1;
    cnt[1] = -1;
    expand(0, PROG_A);
    expand(1, PROG_B);
    check_val("R1", "default op count", n_ops[0], 224);
    check_val("R10", "second op count", n_ops[1], 64);
    tick(4);
    rst_n = 1'b1;
    tick(3);
    // R8: first run, with a start pulse during the run that must be ignored
    pulse_start();
    tick(40);
    pulse_start();
    wait_done();
    // R8: restart from done
    pulse_start();
    tick(101);
    // R9: reset in the middle of a run
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(5);
    pulse_start();
    wait_done();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule